// File: doc/BRIEF.md
# Stream Cipher Core Permutation

This block applies the add-rotate-xor core permutation of a ChaCha-family stream cipher to a 4x4 matrix of 32-bit words. The caller presents the sixteen words in parallel with a round count and pulses `start`. The block then iterates double rounds, one per two clock cycles. Each double round is a column pass followed by a diagonal pass. A final feedforward adds the saved input matrix back into the permuted state. The 512-bit result is held on `outWords` and flagged by a one-cycle `done` strobe.

Four quarter-round lanes run side by side, one per column. The diagonal pass reuses these lanes. It rotates the second, third and fourth rows left by one, two and three word positions, runs the lanes, and then rotates the rows back. No separate diagonal wiring is needed.

Top module: `chacha_core`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `outWords` is all zeros.
- R2: Word k of the matrix occupies bits [32k+31:32k] of `inWords` and `outWords`. Rows are a = words 0-3, b = 4-7, c = 8-11 and d = 12-15. A quarter-round on (a,b,c,d) is: a+=b, d^=a, d<<<=16, c+=d, b^=c, b<<<=12, a+=b, d^=a, d<<<=8, c+=d, b^=c, b<<<=7, with all sums taken mod 2^32. With a round count of 20, the output matches the published 20-round block-function test vector.
- R3: A column pass applies the quarter-round to words (i, 4+i, 8+i, 12+i) for each i. A diagonal pass applies it to (i, 4+(i+1)%4, 8+(i+2)%4, 12+(i+3)%4), and every word then returns to its own position. For any input, the outputs for 8 and 12 rounds equal a software model of this definition.
- R4: The number of double rounds run is floor(rounds/2). An odd count gives the same result as the next lower even count.
- R5: A round count of 0 or 1 gives output word k equal to 2*input word k mod 2^32.
- R6: Suppose `start` is taken at clock edge E. Then `done` is 1 for exactly one cycle, following edge E + 2*floor(rounds/2) + 1.
- R7: `start` is accepted only while `busy` is 0. A `start` seen while `busy` is 1 changes neither the result nor the timing.
- R8: `outWords` changes only at the edge that raises `done`, and holds its value at all other times.
- R9: A `start` given in the cycle in which `done` is high is accepted. The new operation runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the input matrix and begin (taken when not busy) |
| rounds | input | ROUND_W | Round count; the LSB is ignored |
| inWords | input | 512 | Input matrix, word k at bits [32k+31:32k] |
| outWords | output | 512 | Permuted matrix plus input, held until the next result |
| done | output | 1 | One-cycle strobe when `outWords` is updated |
| busy | output | 1 | High from the cycle after `start` until the result is written |

## Verification
The coincidence that matters here is the completion of one block, with its `done` strobe and result write, in the same cycle as the load of the next block. The bench provokes it by raising `start` with fresh data in the very cycle it observes `done`. It then checks that the first result was intact in that cycle, and that the second result and its latency match the model. A second overlap is a `start` that arrives mid-run. The bench judges it by checking that the running block's result and latency are unchanged.

// File: rtl/chacha_core_pkg.sv
package chacha_core_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 16;
  localparam int N_LANES = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic load;
    logic colPass;
    logic diagPass;
    logic finish;
  } ctrl_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/cc_quarter.sv
module cc_quarter
  import chacha_core_pkg::*;
(
  input  word_t aIn,
  input  word_t bIn,
  input  word_t cIn,
  input  word_t dIn,
  output word_t aOut,
  output word_t bOut,
  output word_t cOut,
  output word_t dOut
);
  word_t a1, b1, c1, d1, a2, b2, c2, d2;

  always_comb begin
    a1 = aIn + bIn;
    d1 = rotl(dIn ^ a1, 16);
    c1 = cIn + d1;
    b1 = rotl(bIn ^ c1, 12);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, 7);
  end

  assign aOut = a2;
  assign bOut = b2;
  assign cOut = c2;
  assign dOut = d2;
endmodule

// File: rtl/cc_control.sv
module cc_control
  import chacha_core_pkg::*;
#(
  parameter int ROUND_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ROUND_W-1:0] rounds,
  output ctrl_t              ctrl,
  output logic               busy,
  output logic               done
);
  localparam int CNT_W = ROUND_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_COL, S_DIAG, S_FIN} state_t;

  state_t           st;
  logic [CNT_W-1:0] dblLeft;
  logic [CNT_W-1:0] dblReq;

  assign dblReq = rounds[ROUND_W-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= S_IDLE;
      dblLeft <= '0;
      done    <= 1'b0;
    end else begin
      done <= (st == S_FIN);
      unique case (st)
        S_IDLE: if (start) begin
          dblLeft <= dblReq;
          st      <= (dblReq == '0) ? S_FIN : S_COL;
        end
        S_COL:  st <= S_DIAG;
        S_DIAG: begin
          dblLeft <= dblLeft - 1'b1;
          st      <= (dblLeft == CNT_W'(1)) ? S_FIN : S_COL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load     = (st == S_IDLE) && start;
    ctrl.colPass  = (st == S_COL);
    ctrl.diagPass = (st == S_DIAG);
    ctrl.finish   = (st == S_FIN);
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/cc_datapath.sv
module cc_datapath
  import chacha_core_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_t                      ctrl,
  input  logic [N_WORDS*WORD_W-1:0]  inWords,
  output logic [N_WORDS*WORD_W-1:0]  outWords
);
  word_t work [N_WORDS];
  word_t orig [N_WORDS];
  word_t nxt  [N_WORDS];
  word_t inArr[N_WORDS];
  word_t qa[N_LANES], qb[N_LANES], qc[N_LANES], qd[N_LANES];
  word_t lb[N_LANES], lc[N_LANES], ld[N_LANES];

  always_comb begin
    for (int k = 0; k < N_WORDS; k++) inArr[k] = inWords[k*WORD_W +: WORD_W];
  end

  // Each lane reads one column; in the diagonal pass rows b, c, d are
  // rotated left by 1, 2, 3 positions before they reach the lanes.
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    localparam int IB = (i + 1) % N_LANES;
    localparam int IC = (i + 2) % N_LANES;
    localparam int ID = (i + 3) % N_LANES;
    assign lb[i] = ctrl.diagPass ? work[N_LANES   + IB] : work[N_LANES   + i];
    assign lc[i] = ctrl.diagPass ? work[2*N_LANES + IC] : work[2*N_LANES + i];
    assign ld[i] = ctrl.diagPass ? work[3*N_LANES + ID] : work[3*N_LANES + i];
    cc_quarter u_qr (
      .aIn(work[i]), .bIn(lb[i]), .cIn(lc[i]), .dIn(ld[i]),
      .aOut(qa[i]), .bOut(qb[i]), .cOut(qc[i]), .dOut(qd[i])
    );
  end

  // Undo the row rotation on the way back into the state.
  always_comb begin
    for (int i = 0; i < N_LANES; i++) begin
      nxt[i] = qa[i];
      if (ctrl.diagPass) begin
        nxt[N_LANES   + (i + 1) % N_LANES] = qb[i];
        nxt[2*N_LANES + (i + 2) % N_LANES] = qc[i];
        nxt[3*N_LANES + (i + 3) % N_LANES] = qd[i];
      end else begin
        nxt[N_LANES   + i] = qb[i];
        nxt[2*N_LANES + i] = qc[i];
        nxt[3*N_LANES + i] = qd[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < N_WORDS; k++) begin
        work[k] <= '0;
        orig[k] <= '0;
      end
      outWords <= '0;
    end else begin
      if (ctrl.load) begin
        for (int k = 0; k < N_WORDS; k++) begin
          work[k] <= inArr[k];
          orig[k] <= inArr[k];
        end
      end else if (ctrl.colPass || ctrl.diagPass) begin
        for (int k = 0; k < N_WORDS; k++) work[k] <= nxt[k];
      end
      if (ctrl.finish) begin
        for (int k = 0; k < N_WORDS; k++)
          outWords[k*WORD_W +: WORD_W] <= work[k] + orig[k];
      end
    end
  end
endmodule

// File: rtl/chacha_core.sv
module chacha_core
  import chacha_core_pkg::*;
#(
  parameter int ROUND_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ROUND_W-1:0] rounds,
  input  logic [511:0]       inWords,
  output logic [511:0]       outWords,
  output logic               done,
  output logic               busy
);
  ctrl_t ctrl;

  cc_control #(.ROUND_W(ROUND_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rounds(rounds),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  cc_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .inWords(inWords), .outWords(outWords)
  );
endmodule

// File: rtl/chacha_core_chk.sv
module chacha_core_chk #(
  parameter int ROUND_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [ROUND_W-1:0] rounds,
  input logic [511:0]       outWords,
  input logic               done,
  input logic               busy
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outWords) |-> done);

  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_zero_rounds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && rounds[ROUND_W-1:1] == '0) |=> ##1 done);
endmodule

bind chacha_core chacha_core_chk #(.ROUND_W(ROUND_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .rounds(rounds),
  .outWords(outWords), .done(done), .busy(busy)
);

// File: tb/chacha_core_tb.sv
module chacha_core_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   rounds = '0;
  logic [511:0] inWords = '0;
  logic [511:0] outWords;
  logic         done, busy;
  int           nChecks = 0;
  int           nFails = 0;

  always #4 clk = ~clk;

  chacha_core u_dut (
    .clk(clk), .rstN(rstN), .start(start), .rounds(rounds),
    .inWords(inWords), .outWords(outWords), .done(done), .busy(busy)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [127:0] qr(input logic [31:0] a, b, c, d);
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
    return {d, c, b, a};
  endfunction

  function automatic logic [511:0] model(input logic [511:0] in, input int r);
    logic [31:0] x[16];
    logic [127:0] t;
    logic [511:0] res;
    int idx[8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                      '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
    for (int k = 0; k < 16; k++) x[k] = in[32*k +: 32];
    for (int dr = 0; dr < r / 2; dr++)
      for (int q = 0; q < 8; q++) begin
        t = qr(x[idx[q][0]], x[idx[q][1]], x[idx[q][2]], x[idx[q][3]]);
        x[idx[q][0]] = t[31:0];   x[idx[q][1]] = t[63:32];
        x[idx[q][2]] = t[95:64];  x[idx[q][3]] = t[127:96];
      end
    for (int k = 0; k < 16; k++) res[32*k +: 32] = x[k] + in[32*k +: 32];
    return res;
  endfunction

  function automatic logic [511:0] pack(input logic [31:0] w[16]);
    logic [511:0] p;
    for (int k = 0; k < 16; k++) p[32*k +: 32] = w[k];
    return p;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] p;
    for (int k = 0; k < 16; k++) p[32*k +: 32] = $urandom;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act, exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [511:0] d, input int r);
    inWords = d; rounds = 8'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Counts negedges since the one where start was raised until done is seen.
  task automatic waitDone(output int lat);
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runOne(input logic [511:0] d, input int r, input string req);
    int lat;
    logic [511:0] exp;
    exp = model(d, r);
    @(negedge clk);
    launch(d, r);
    waitDone(lat);
    check(outWords == exp, req, outWords, exp);
    check(lat == 2 * (r / 2) + 2, "R6 latency", 512'(lat), 512'(2 * (r / 2) + 2));
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", 512'(done), 512'(0));
  endtask

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] vin[16] = '{32'h61707865, 32'h3320646e, 32'h79622d32, 32'h6b206574,
                             32'h03020100, 32'h07060504, 32'h0b0a0908, 32'h0f0e0d0c,
                             32'h13121110, 32'h17161514, 32'h1b1a1918, 32'h1f1e1d1c,
                             32'h00000001, 32'h09000000, 32'h4a000000, 32'h00000000};
    logic [31:0] vout[16] = '{32'he4e7f110, 32'h15593bd1, 32'h1fdd0f50, 32'hc47120a3,
                              32'hc7f4d1c7, 32'h0368c033, 32'h9aaa2204, 32'h4e6cd4c3,
                              32'h466482d2, 32'h09aa9f07, 32'h05d7c214, 32'ha2028bd9,
                              32'hd19c12b5, 32'hb94e16de, 32'he883d0cb, 32'h4e3c50a2};
    logic [511:0] a, b, c, expA, expC, dbl, held;
    int lat;
    void'($urandom(32'd20240607));

    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 0 && busy == 0 && outWords == '0, "R1 reset", {outWords[509:0], done, busy}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 published vector, 20 rounds
    @(negedge clk);
    launch(pack(vin), 20);
    waitDone(lat);
    check(outWords == pack(vout), "R2 test vector", outWords, pack(vout));
    check(lat == 22, "R6 latency 20 rounds", 512'(lat), 512'(22));
    held = outWords;
    repeat (3) @(negedge clk);
    check(outWords == held, "R8 output held", outWords, held);

    // R3 column/diagonal structure at 8 and 12 rounds
    runOne(rnd512(), 8, "R3 eight rounds");
    runOne(rnd512(), 12, "R3 twelve rounds");
    runOne('0, 8, "R3 zero matrix");
    runOne({16{32'hffffffff}}, 12, "R3 all ones");

    // R4 odd count equals lower even count
    a = rnd512();
    runOne(a, 9, "R4 odd nine");
    check(outWords == model(a, 8), "R4 nine equals eight", outWords, model(a, 8));

    // R5 zero and one rounds
    a = rnd512();
    for (int k = 0; k < 16; k++) dbl[32*k +: 32] = a[32*k +: 32] << 1;
    runOne(a, 0, "R5 zero rounds");
    check(outWords == dbl, "R5 doubled", outWords, dbl);
    runOne(a, 1, "R5 one round");

    // R7 start while busy is ignored
    a = rnd512(); b = rnd512();
    expA = model(a, 20);
    @(negedge clk);
    launch(a, 20);
    @(negedge clk); @(negedge clk);
    inWords = b; rounds = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    check(outWords == expA, "R7 start ignored result", outWords, expA);
    check(lat == 22, "R7 start ignored latency", 512'(lat), 512'(22));

    // R9 back-to-back: new start in the done cycle
    c = rnd512();
    expC = model(c, 8);
    inWords = c; rounds = 8'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(outWords == expA, "R9 first result intact", outWords, expA);
    check(busy == 1'b1, "R9 second start accepted", 512'(busy), 512'(1));
    waitDone(lat);
    check(outWords == expC, "R9 second result", outWords, expC);
    check(lat == 10, "R9 second latency", 512'(lat), 512'(10));

    // Random mix
    for (int n = 0; n < 12; n++) begin
      int r = $urandom_range(0, 21);
      runOne(rnd512(), r, "R4 random rounds");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule